// File: doc/BRIEF.md
# Amplifier Power-Up and Mute Sequencer

This block steps a switching power stage through its operating states. An active-low standby input and an active-low silence input drive it, and it runs on the master clock. When the chip is in standby, the modulator is stopped and the output bridge is held in high impedance. When standby is released, the modulator starts at once. The bridge stays quiet for a fixed internal hold-off interval, and then waits for silence to be released. Extra counted delays are placed before the bridge starts switching and before it stops. These delays keep turn-on and turn-off free of pops.

The protection logic supplies three inputs: a fault flag and two undervoltage flags, one for the logic supply and one for the bridge supply. Each of these only forces the bridge off and keeps it from turning on again. The first cycle of every bridge turn-on carries a ramp request to the soft-start circuit. Every interval is a cycle-count parameter. The defaults are 650 ms, 200 µs and 200 µs at a 24.576 MHz clock.

Top module: `amp_unmute_seq`

## Requirements
- R1: While standby_n_i is low, mod_run_o and bridge_drive_o are low. A low standby_n_i brings both outputs low 3 clock edges after it is applied, from any state.
- R2: When standby_n_i rises, mod_run_o rises 3 clock edges later: 2 of these are for synchronization and 1 is for the state change. bridge_drive_o stays low.
- R3: For HOLD_CYC cycles after mod_run_o rises, bridge_drive_o stays low even if silence_n_i is already high. If silence_n_i is high from the start, bridge_drive_o rises HOLD_CYC+ON_CYC+1 edges after mod_run_o rises.
- R4: From the idle muted state, after the hold-off has ended, a rising silence_n_i raises bridge_drive_o after 3+ON_CYC edges. If silence_n_i falls during this on-delay, the turn-on is cancelled, and the next turn-on takes the full delay again.
- R5: ramp_req_o is high for exactly one cycle, and that cycle is the first cycle of each bridge_drive_o high period.
- R6: A falling silence_n_i while the bridge is driven lowers bridge_drive_o after 3+OFF_CYC edges. mod_run_o stays high.
- R7: While either logic_uv_i or rail_uv_i is high, bridge_drive_o cannot rise. Setting either flag while the bridge is driven lowers bridge_drive_o one edge later. When both flags clear with silence_n_i high, bridge_drive_o rises after 1+ON_CYC edges.
- R8: A high prot_fault_i lowers bridge_drive_o one edge later and skips the off-delay. The bridge stays off while the fault is present. Clearing the fault with silence_n_i high restarts the on-delay, and bridge_drive_o rises after 1+ON_CYC edges.
- R9: Entering standby clears all timing. A new release of standby_n_i always runs the full hold-off again.
- R10: While rst_n is low, all three outputs are low, and this takes effect immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n_i | input | 1 | Active-low standby request (asynchronous) |
| silence_n_i | input | 1 | Active-low mute request (asynchronous) |
| prot_fault_i | input | 1 | Protection fault, forces the bridge off (synchronous) |
| logic_uv_i | input | 1 | Logic-supply undervoltage (synchronous) |
| rail_uv_i | input | 1 | Bridge-supply undervoltage (synchronous) |
| mod_run_o | output | 1 | Modulator enable |
| bridge_drive_o | output | 1 | Bridge switching enable; low means high impedance |
| ramp_req_o | output | 1 | One-cycle soft-start request at bridge turn-on |

## Verification
The bench builds the block with HOLD_CYC=40, ON_CYC=6 and OFF_CYC=5 instead of the millisecond defaults. With these values, every path (the full hold-off, a hold-off cut short by standby, and cancelled and completed on-delays) finishes within a few hundred cycles. Each expected transition is sampled exactly one edge before and on the edge where it must happen. The short counts also make the ordering corners quick to reach: silence released together with standby, a supply flag swapped for the other in the same cycle, and a fault held for longer than the on-delay.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY = 3'd0,
    ST_HOLD    = 3'd1,
    ST_QUIET   = 3'd2,
    ST_RAMP_ON = 3'd3,
    ST_DRIVE   = 3'd4,
    ST_RAMP_OFF= 3'd5
  } seq_state_e;

  // Counter width able to hold the largest of three cycle counts.
  function automatic int unsigned span_bits(int unsigned a, int unsigned b, int unsigned c);
    int unsigned mx;
    mx = a;
    if (b > mx) mx = b;
    if (c > mx) mx = c;
    return (mx < 2) ? 1 : $clog2(mx + 1);
  endfunction

  // Output decode shared by the sequencer.
  function automatic logic bridge_on(seq_state_e s);
    return (s == ST_DRIVE) || (s == ST_RAMP_OFF);
  endfunction

endpackage

// File: rtl/seq_sync2.sv
module seq_sync2 #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R4: a running count only moves down by one per cycle
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));
endmodule

// File: rtl/amp_unmute_seq.sv
module amp_unmute_seq #(
  parameter int unsigned HOLD_CYC = 15974400,
  parameter int unsigned ON_CYC   = 4915,
  parameter int unsigned OFF_CYC  = 4915
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_n_i,
  input  logic silence_n_i,
  input  logic prot_fault_i,
  input  logic logic_uv_i,
  input  logic rail_uv_i,
  output logic mod_run_o,
  output logic bridge_drive_o,
  output logic ramp_req_o
);
  import amp_seq_pkg::*;

  localparam int unsigned TW = span_bits(HOLD_CYC, ON_CYC, OFF_CYC);
  localparam logic [TW-1:0] HOLD_LEN = TW'(HOLD_CYC);
  localparam logic [TW-1:0] ON_LEN   = TW'(ON_CYC);
  localparam logic [TW-1:0] OFF_LEN  = TW'(OFF_CYC);

  // Synchronized controls; reset value means standby and muted.
  logic [1:0] sync_q;
  logic       awake_s, unmute_s;
  seq_sync2 #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({standby_n_i, silence_n_i}),
    .q_o   (sync_q)
  );
  assign awake_s  = sync_q[1];
  assign unmute_s = sync_q[0];

  // Named internal events, used by the assertions.
  logic       block_pwr;
  logic       tmr_load, tmr_done;
  logic [TW-1:0] tmr_len;
  logic       ramp_nxt;
  seq_state_e st_q, st_d;

  assign block_pwr = prot_fault_i | logic_uv_i | rail_uv_i;

  seq_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    ramp_nxt = 1'b0;
    if (!awake_s) begin
      st_d = ST_STANDBY;
    end else begin
      unique case (st_q)
        ST_STANDBY: begin
          st_d     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = HOLD_LEN;
        end
        ST_HOLD: begin
          if (tmr_done) st_d = ST_QUIET;
        end
        ST_QUIET: begin
          if (unmute_s && !block_pwr) begin
            st_d     = ST_RAMP_ON;
            tmr_load = 1'b1;
            tmr_len  = ON_LEN;
          end
        end
        ST_RAMP_ON: begin
          if (!unmute_s || block_pwr) begin
            st_d = ST_QUIET;
          end else if (tmr_done) begin
            st_d     = ST_DRIVE;
            ramp_nxt = 1'b1;
          end
        end
        ST_DRIVE: begin
          if (block_pwr) begin
            st_d = ST_QUIET;
          end else if (!unmute_s) begin
            st_d     = ST_RAMP_OFF;
            tmr_load = 1'b1;
            tmr_len  = OFF_LEN;
          end
        end
        ST_RAMP_OFF: begin
          if (block_pwr || tmr_done) st_d = ST_QUIET;
        end
        default: st_d = ST_STANDBY;
      endcase
    end
  end

  logic ramp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_STANDBY;
      ramp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ramp_q <= ramp_nxt;
    end
  end

  assign mod_run_o      = (st_q != ST_STANDBY);
  assign bridge_drive_o = bridge_on(st_q);
  assign ramp_req_o     = ramp_q;

  // R1: the bridge never switches without the modulator
  p_bridge_needs_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_drive_o |-> mod_run_o);

  // R1: synchronized standby stops the modulator on the next edge
  p_standby_stops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !awake_s |=> !mod_run_o);

  // R4: the bridge only starts after a finished on-delay
  p_on_after_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_drive_o) |-> $past(tmr_done));

  // R5: every turn-on carries the ramp request
  p_ramp_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_drive_o) |-> ramp_req_o);

  // R5: ramp request lasts a single cycle
  p_ramp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_req_o |=> !ramp_req_o);

  // R7: supply flags keep the bridge off
  p_uv_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_uv_i || rail_uv_i) |=> !bridge_drive_o);

  // R8: a fault turns the bridge off on the next edge
  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault_i |=> !bridge_drive_o);
endmodule

// File: tb/tb_amp_unmute_seq.sv
module tb_amp_unmute_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 40;
  localparam int ONC  = 6;
  localparam int OFFC = 5;
  localparam int NVEC = 31;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_n = 1'b0, silence_n = 1'b0, fault = 1'b0, luv = 1'b0, ruv = 1'b0;
  logic mod_run, bridge, ramp;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_unmute_seq #(.HOLD_CYC(HOLD), .ON_CYC(ONC), .OFF_CYC(OFFC)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .standby_n_i   (standby_n),
    .silence_n_i   (silence_n),
    .prot_fault_i  (fault),
    .logic_uv_i    (luv),
    .rail_uv_i     (ruv),
    .mod_run_o     (mod_run),
    .bridge_drive_o(bridge),
    .ramp_req_o    (ramp)
  );

  // Vector: {req[3:0], inputs {standby,silence,fault,luv,ruv}, wait[15:0], exp {mod,bridge,ramp}}
  function automatic logic [27:0] vec(int r, logic [4:0] ins, int w, logic [2:0] e);
    return {4'(r), ins, 16'(w), e};
  endfunction

  localparam logic [27:0] VEC [NVEC] = '{
    vec(2, 5'b10000, 2,           3'b000), // R2 not yet awake
    vec(2, 5'b10000, 1,           3'b100), // R2 modulator on
    vec(3, 5'b11000, HOLD+ONC,    3'b100), // R3 early unmute held off
    vec(3, 5'b11000, 1,           3'b111), // R3 R5 turn-on
    vec(5, 5'b11000, 1,           3'b110), // R5 ramp gone
    vec(6, 5'b10000, 2+OFFC,      3'b110), // R6 still in off-delay
    vec(6, 5'b10000, 1,           3'b100), // R6 bridge off
    vec(4, 5'b11000, 2+ONC,       3'b100), // R4 on-delay running
    vec(4, 5'b11000, 1,           3'b111), // R4 on
    vec(8, 5'b11100, 1,           3'b100), // R8 fault off in one edge
    vec(8, 5'b11100, 10,          3'b100), // R8 held off
    vec(8, 5'b11000, ONC,         3'b100), // R8 delay restarts
    vec(8, 5'b11000, 1,           3'b111), // R8 on again
    vec(7, 5'b11001, 1,           3'b100), // R7 rail flag
    vec(7, 5'b11010, 20,          3'b100), // R7 logic flag swapped in
    vec(7, 5'b11000, ONC,         3'b100), // R7 delay after clear
    vec(7, 5'b11000, 1,           3'b111), // R7 on
    vec(1, 5'b01000, 2,           3'b110), // R1 not yet seen
    vec(1, 5'b01000, 1,           3'b000), // R1 standby
    vec(3, 5'b11000, 2+HOLD,      3'b100), // R3 wake with unmute held
    vec(3, 5'b11000, 1+ONC,       3'b100), // R3 one edge short
    vec(3, 5'b11000, 1,           3'b111), // R3 on
    vec(9, 5'b01000, 3,           3'b000), // R9 standby
    vec(9, 5'b11000, 13,          3'b100), // R9 partial hold-off
    vec(9, 5'b01000, 3,           3'b000), // R9 standby mid hold-off
    vec(9, 5'b11000, 3+HOLD+ONC,  3'b100), // R9 full hold-off again
    vec(9, 5'b11000, 1,           3'b111), // R9 on
    vec(6, 5'b10000, 3+OFFC,      3'b100), // R6 off
    vec(4, 5'b11000, 3,           3'b100), // R4 in on-delay
    vec(4, 5'b10000, ONC+5,       3'b100), // R4 cancelled
    vec(4, 5'b11000, 3+ONC,       3'b111)  // R4 full delay again
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic cmp(int r, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b", r, what, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    // R10: outputs low during reset
    repeat (3) @(negedge clk);
    cmp(10, "mod_run in reset", mod_run, 1'b0);
    cmp(10, "bridge in reset",  bridge,  1'b0);
    cmp(10, "ramp in reset",    ramp,    1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cmp(10, "mod_run idle", mod_run, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      {standby_n, silence_n, fault, luv, ruv} = v[23:19];
      for (int k = 0; k < int'(v[18:3]); k++) @(posedge clk);
      @(negedge clk);
      cmp(int'(v[27:24]), $sformatf("vec %0d mod_run", i), mod_run, v[2]);
      cmp(int'(v[27:24]), $sformatf("vec %0d bridge", i),  bridge,  v[1]);
      cmp(int'(v[27:24]), $sformatf("vec %0d ramp", i),    ramp,    v[0]);
    end

    // R10: asynchronous reset while driving
    rst_n = 1'b0;
    #1;
    cmp(10, "mod_run async reset", mod_run, 1'b0);
    cmp(10, "bridge async reset",  bridge,  1'b0);
    done_run = 1'b1;
    finish_run();
  end
endmodule